// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns 32-bit virtual addresses from a processor into 30-bit physical addresses. Pages are 4 KB, so the low 12 bits of an address are carried through unchanged and the upper 20 bits select a page. A lookup first searches a small fully associative cache of recent translations. On a hit the result comes back without any memory traffic. On a miss a walker reads one entry of a single-level page table from memory. The entry sits at the table base plus four bytes per page. The walker then checks the entry and reports one of three results: a physical address, a page fault, or a protection fault.

Software loads the table base through a write strobe. Loading a new base empties the translation cache, so a mapping that belongs to one address space is never applied to another. The unit handles one lookup at a time. It never repairs a fault: it only reports the fault and the virtual address that caused it.

Top module: `page_xlate`

## Requirements
- R1: On success, rspPaddr is the entry's 18-bit physical page number in bits 29:12 and the lookup's virtual bits 11:0 in bits 11:0.
- R2: On a miss, memReqAddr equals the table base plus four times the virtual page number (virtual bits 31:12). memReqValid and memReqAddr hold steady until a cycle with memRspValid high, which may come after any number of stall cycles.
- R3: The memory port returns a 21-bit entry: bit 20 present, bit 19 read allowed, bit 18 write allowed, bits 17:0 physical page number.
- R4: An entry with its present bit clear gives rspPageFault=1, rspProtFault=0, rspPaddr=0 and rspFaultVaddr equal to the lookup's virtual address. A response without a fault gives rspFaultVaddr=0.
- R5: A present entry whose right for the requested access is clear (write right when reqWrite=1, read right when reqWrite=0) gives rspProtFault=1, rspPageFault=0, rspPaddr=0 and rspFaultVaddr equal to the virtual address.
- R6: A lookup that hits the translation cache makes no memory request. Its rspValid pulse comes one cycle after the clock edge that accepted the request.
- R7: On a miss, the rspValid pulse comes in the cycle after the cycle in which memRspValid was high.
- R8: The cache holds 8 translations and is refilled in round-robin order. A ninth distinct present page evicts the oldest one. A page is never held twice.
- R9: A base write, made while no lookup is in progress, invalidates every cached translation. The next lookup of any page walks the table at the new base.
- R10: A page-fault entry is never cached, so a repeated lookup of that page walks the table again. Present entries are cached even when they raise a protection fault.
- R11: reqReady is high only while no lookup is in flight. rspValid is a single-cycle pulse. rspPageFault and rspProtFault are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baseWrEn | input | 1 | Load the page-table base and flush the cache |
| baseWrData | input | 32 | New page-table base byte address |
| reqValid | input | 1 | Lookup request |
| reqReady | output | 1 | Unit idle, request accepted this cycle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a store, 0 for a load |
| rspValid | output | 1 | One-cycle result pulse |
| rspPaddr | output | 30 | Physical address, zero on a fault |
| rspPageFault | output | 1 | Entry not present |
| rspProtFault | output | 1 | Access not permitted |
| rspFaultVaddr | output | 32 | Faulting virtual address, zero otherwise |
| memReqValid | output | 1 | Entry read request, held until answered |
| memReqAddr | output | 32 | Byte address of the entry |
| memRspValid | input | 1 | Entry data valid |
| memRspData | input | 21 | Entry contents |

## Verification
Some properties are checked on every cycle by assertions: the two fault flags never rise together, a fault never carries an address, the page offset passes through, the response is a single pulse, the entry request is held steady while memory stalls, a base write leaves no valid cache entry, and no two cache entries hit at once. Other behaviour can only be shown by the bench's scenarios, which sweep pages with mixed rights across three passes. These scenarios cover whether a given lookup hits or walks under round-robin eviction, the re-walk of fault pages, the flush after a base change, and the exact response latency for hits and for walks with varied memory stalls.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WALK
  } xlateState_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic acceptReq;   // capture the incoming lookup
    logic finishHit;   // respond from the cache
    logic finishWalk;  // respond from the fetched entry
    logic refill;      // write the fetched entry into the cache
  } xlateStrobes_t;

endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          cacheHit,
  input  logic          memRspValid,
  input  logic          pteValid,
  output logic          reqReady,
  output logic          memReqValid,
  output xlateStrobes_t stb
);

  xlateState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        stb.acceptReq = reqValid;
        if (reqValid) stateNext = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        stb.finishHit = cacheHit;
        stateNext     = cacheHit ? ST_IDLE : ST_WALK;
      end
      ST_WALK: begin
        stb.finishWalk = memRspValid;
        stb.refill     = memRspValid && pteValid;
        if (memRspValid) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_WALK);

  // R2: an unanswered entry request is still raised next cycle
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid);

  // R11: after accepting a lookup the unit is busy
  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptReq |=> !reqReady);

  // R6: a hit never starts a table read
  assert_hit_no_walk_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP) && cacheHit |=> !memReqValid);

endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OFFS_W   = 12,
  parameter int PPN_W    = 18,
  parameter int NUM_WAYS = 8,
  localparam int VPN_W   = VA_W - OFFS_W,
  localparam int PA_W    = PPN_W + OFFS_W,
  localparam int PTE_W   = PPN_W + 3,
  localparam int PTR_W   = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobes_t     stb,
  input  logic              baseWrEn,
  input  logic [VA_W-1:0]   baseWrData,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              cacheHit,
  output logic              pteValid,
  output logic [VA_W-1:0]   memReqAddr,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspPageFault,
  output logic              rspProtFault,
  output logic [VA_W-1:0]   rspFaultVaddr
);

  logic [VA_W-1:0]  baseQ, vaddrQ;
  logic             writeQ;
  logic [VPN_W-1:0] vpnQ;
  assign vpnQ = vaddrQ[VA_W-1:OFFS_W];

  // Translation cache storage
  logic [NUM_WAYS-1:0] entValid, entRd, entWr, hitVec;
  logic [VPN_W-1:0]    entTag [NUM_WAYS];
  logic [PPN_W-1:0]    entPpn [NUM_WAYS];
  logic [PTR_W-1:0]    fillPtr;

  for (genvar gi = 0; gi < NUM_WAYS; gi++) begin : g_match
    assign hitVec[gi] = entValid[gi] && (entTag[gi] == vpnQ);
  end

  logic [PPN_W-1:0] hitPpn;
  logic             hitRd, hitWr;
  always_comb begin
    hitPpn = '0;
    hitRd  = 1'b0;
    hitWr  = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (hitVec[i]) begin
        hitPpn = hitPpn | entPpn[i];
        hitRd  = hitRd  | entRd[i];
        hitWr  = hitWr  | entWr[i];
      end
    end
  end
  assign cacheHit = |hitVec;

  // Fetched entry fields
  logic             pteRd, pteWr;
  logic [PPN_W-1:0] ptePpn;
  assign pteValid = memRspData[PTE_W-1];
  assign pteRd    = memRspData[PTE_W-2];
  assign pteWr    = memRspData[PTE_W-3];
  assign ptePpn   = memRspData[PPN_W-1:0];

  assign memReqAddr = baseQ + VA_W'({vpnQ, 2'b00});

  // Result selection and checks
  logic             srcPresent, srcRd, srcWr, pageFault, protFault, done;
  logic [PPN_W-1:0] srcPpn;
  always_comb begin
    srcPresent = stb.finishHit ? 1'b1   : pteValid;
    srcRd      = stb.finishHit ? hitRd  : pteRd;
    srcWr      = stb.finishHit ? hitWr  : pteWr;
    srcPpn     = stb.finishHit ? hitPpn : ptePpn;
    pageFault  = !srcPresent;
    protFault  = srcPresent && (writeQ ? !srcWr : !srcRd);
  end
  assign done = stb.finishHit || stb.finishWalk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ         <= '0;
      vaddrQ        <= '0;
      writeQ        <= 1'b0;
      rspValid      <= 1'b0;
      rspPaddr      <= '0;
      rspPageFault  <= 1'b0;
      rspProtFault  <= 1'b0;
      rspFaultVaddr <= '0;
    end else begin
      if (baseWrEn) baseQ <= baseWrData;
      if (stb.acceptReq) begin
        vaddrQ <= reqVaddr;
        writeQ <= reqWrite;
      end
      rspValid <= done;
      if (done) begin
        rspPageFault  <= pageFault;
        rspProtFault  <= protFault;
        rspPaddr      <= (pageFault || protFault) ? '0 : {srcPpn, vaddrQ[OFFS_W-1:0]};
        rspFaultVaddr <= (pageFault || protFault) ? vaddrQ : '0;
      end
    end
  end

  // Cache refill, round robin; flush wins over refill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entRd    <= '0;
      entWr    <= '0;
      fillPtr  <= '0;
      for (int i = 0; i < NUM_WAYS; i++) begin
        entTag[i] <= '0;
        entPpn[i] <= '0;
      end
    end else if (baseWrEn) begin
      entValid <= '0;
    end else if (stb.refill) begin
      entValid[fillPtr] <= 1'b1;
      entRd[fillPtr]    <= pteRd;
      entWr[fillPtr]    <= pteWr;
      entTag[fillPtr]   <= vpnQ;
      entPpn[fillPtr]   <= ptePpn;
      fillPtr           <= (fillPtr == PTR_W'(NUM_WAYS - 1)) ? '0 : fillPtr + 1'b1;
    end
  end

  assert_unique_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> (entValid == '0));

  assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspPageFault || rspProtFault) |-> (rspPaddr == '0));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspPageFault && !rspProtFault |-> rspPaddr[OFFS_W-1:0] == vaddrQ[OFFS_W-1:0]);

  assert_fault_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspPageFault && rspProtFault));

endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OFFS_W   = 12,
  parameter int PPN_W    = 18,
  parameter int NUM_WAYS = 8,
  localparam int PA_W    = PPN_W + OFFS_W,
  localparam int PTE_W   = PPN_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseWrEn,
  input  logic [VA_W-1:0]  baseWrData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspPageFault,
  output logic             rspProtFault,
  output logic [VA_W-1:0]  rspFaultVaddr,
  output logic             memReqValid,
  output logic [VA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData
);

  xlateStrobes_t stb;
  logic          cacheHit, pteValid;

  page_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .cacheHit   (cacheHit),
    .memRspValid(memRspValid),
    .pteValid   (pteValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .stb        (stb)
  );

  page_xlate_dp #(
    .VA_W    (VA_W),
    .OFFS_W  (OFFS_W),
    .PPN_W   (PPN_W),
    .NUM_WAYS(NUM_WAYS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .baseWrEn     (baseWrEn),
    .baseWrData   (baseWrData),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .memRspData   (memRspData),
    .cacheHit     (cacheHit),
    .pteValid     (pteValid),
    .memReqAddr   (memReqAddr),
    .rspValid     (rspValid),
    .rspPaddr     (rspPaddr),
    .rspPageFault (rspPageFault),
    .rspProtFault (rspProtFault),
    .rspFaultVaddr(rspFaultVaddr)
  );

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> $stable(memReqAddr));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: tb/page_xlate_bench.sv
`timescale 1ns/1ps
module page_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic [29:0] rspPaddr;
  logic        rspPageFault, rspProtFault;
  logic [31:0] rspFaultVaddr;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [20:0] memRspData = '0;

  always #2 clk = ~clk;

  page_xlate u_page_xlate (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspPageFault(rspPageFault),
    .rspProtFault(rspProtFault), .rspFaultVaddr(rspFaultVaddr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int checks = 0, fails = 0, cycle = 0, memReads = 0, lastRspCycle = -10, waitCnt = 0;
  logic [31:0] curBase = '0;
  logic [19:0] curVpn = '0;
  bit          flushed = 1'b0;

  // Model of the translation cache contents
  logic [19:0] mTag [8];
  bit          mVal [8];
  int          mPtr = 0;

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3 entry layout: bit 20 present, 19 read, 18 write, 17:0 page number
  function automatic logic [20:0] pteOf(logic [19:0] vpn);
    int v;
    logic [17:0] ppn;
    v   = int'(vpn);
    ppn = 18'((v * 37 + 5) % 262144);
    return {((v % 7) != 3), ((v % 4) != 1), ((v % 3) == 0), ppn};
  endfunction

  always @(posedge clk) begin
    cycle++;
    if (cycle > 100000) begin
      fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected=<100000", cycle);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Memory with a variable stall before each answer
  always @(negedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid && !memRspValid) begin
      if (waitCnt == 0) begin
        checkEq("R2 entry address", memReqAddr, curBase + {10'd0, curVpn, 2'b00});
        memRspValid  <= 1'b1;
        memRspData   <= pteOf(curVpn);
        memReads++;
        lastRspCycle = cycle;
        waitCnt      = memReads % 4;
      end else begin
        waitCnt--;
      end
    end
  end

  task automatic setBase(logic [31:0] b);
    @(negedge clk);
    baseWrEn   = 1'b1;
    baseWrData = b;
    @(posedge clk);
    @(negedge clk);
    baseWrEn = 1'b0;
    curBase  = b;
    for (int i = 0; i < 8; i++) mVal[i] = 1'b0;
    flushed = 1'b1;
  endtask

  task automatic lookup(logic [19:0] vpn, logic [11:0] offs, bit wr);
    bit          expHit, expPf, expPr;
    logic [20:0] p;
    logic [29:0] expPa;
    int          reads0, acceptCycle, waited;
    string       missTag;
    expHit = 1'b0;
    for (int i = 0; i < 8; i++) if (mVal[i] && mTag[i] == vpn) expHit = 1'b1;
    p     = pteOf(vpn);
    expPf = !p[20];
    expPr = p[20] && (wr ? !p[18] : !p[19]);
    expPa = (expPf || expPr) ? 30'd0 : {p[17:0], offs};
    if (flushed) missTag = "R9 walk after base write";
    else if (!p[20]) missTag = "R10 fault page walked again";
    else missTag = "R8 miss walks table";
    if (!expHit && p[20]) begin
      mTag[mPtr] = vpn;
      mVal[mPtr] = 1'b1;
      mPtr       = (mPtr + 1) % 8;
    end
    curVpn = vpn;
    reads0 = memReads;
    @(negedge clk);
    checkEq("R11 ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqVaddr = {vpn, offs};
    reqWrite = wr;
    @(posedge clk);
    @(negedge clk);
    reqValid    = 1'b0;
    acceptCycle = cycle;
    checkEq("R11 busy after accept", 32'(reqReady), 32'd0);
    waited = 0;
    while (!rspValid && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    checkEq("R11 response arrives", 32'(rspValid), 32'd1);
    if (expHit) begin
      checkEq("R6 hit without memory read", 32'(memReads - reads0), 32'd0);
      checkEq("R6 hit latency", 32'(cycle - acceptCycle), 32'd1);
    end else begin
      checkEq(missTag, 32'(memReads - reads0), 32'd1);
      checkEq("R7 walk latency", 32'(cycle), 32'(lastRspCycle + 1));
    end
    checkEq("R4 page fault flag", 32'(rspPageFault), 32'(expPf));
    checkEq("R5 protection fault flag", 32'(rspProtFault), 32'(expPr));
    checkEq("R1 physical address", 32'(rspPaddr), 32'(expPa));
    checkEq("R4 fault address", rspFaultVaddr, (expPf || expPr) ? {vpn, offs} : 32'd0);
    @(negedge clk);
    checkEq("R11 single pulse", 32'(rspValid), 32'd0);
    flushed = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mVal[i] = 1'b0;
      mTag[i] = '0;
    end
    repeat (3) @(negedge clk);
    checkEq("R11 reset ready", 32'(reqReady), 32'd1);
    checkEq("R11 reset no response", 32'(rspValid), 32'd0);
    checkEq("R2 reset no memory request", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    setBase(32'h0010_0000);
    for (int pass = 0; pass < 3; pass++)
      for (int v = 0; v < 12; v++)
        for (int w = 0; w < 2; w++)
          lookup(20'hA00 + 20'(v), 12'((v * 291 + w * 1000 + pass * 77) % 4096), w[0]);
    // R9: new base flushes; same pages walk again at the new base
    setBase(32'h0023_4000);
    for (int v = 0; v < 4; v++) lookup(20'hA00 + 20'(v), 12'hABC, 1'b0);
    for (int v = 0; v < 4; v++) lookup(20'hA00 + 20'(v), 12'h123, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule